// File: doc/BRIEF.md
# Digital Clock Frequency Corrector

This block sits next to the prescaler that divides a slow reference clock down to a one-pulse-per-second tick. It trims that timebase to make up for a reference oscillator that runs fast or slow. A signed correction value sets how many single-cycle adjustments are made in each correction window. A positive value speeds the tick up and a negative value slows it down. The window is a fixed number of adjustment slots. Each slot is a fixed number of input cycles long, and at most one adjustment happens per slot. With the default sizes (976 slots of 1024 cycles), one step per window is a trim of 1/999424, which is about 1.0 ppm. The maximum of 127 steps gives about 127 ppm.

The steps are spread across the window with a Bresenham-style accumulator rather than bunched together. A step up moves the prescaler forward by two in one cycle. A step down holds the prescaler for one cycle. The block also contains the prescaler, which is a power-of-two counter of at least four states. Its wrap produces the corrected tick.

The controller is a three-state machine:
- **ST_IDLE**: everything is cleared.
- **ST_LOAD**: one cycle in which the correction value is captured.
- **ST_COUNT**: the slots and the window are counted.

The transitions are:
- *arm*: ST_IDLE to ST_LOAD, when the enable input is high.
- *start*: ST_LOAD to ST_COUNT.
- *window wrap*: ST_COUNT to ST_COUNT at the end of the last slot, where the value is captured again.
- *disarm*: any state to ST_IDLE, when the enable input is low.

Top module: `dfc_corrector`

## Requirements
- R1: After reset, and from the second cycle after `en` is sampled low, `step_up`, `step_down` and `tick_1hz` are all 0. The prescaler restarts from zero on the next enable.
- R2: A strobe can occur only in the last cycle of a slot. The load cycle (the cycle after `en` is first sampled high) is cycle 0, and a strobe cycle index is a nonzero multiple of SLOT_LEN. At most one strobe occurs per slot.
- R3: Each window of WINDOW_SLOTS×SLOT_LEN cycles after the load cycle gives exactly |value| strobes. The value is read as 8-bit two's complement, and the code 0x80 (-128) counts as magnitude 127.
- R4: A value with bit 7 clear produces only `step_up`. A value with bit 7 set produces only `step_down`. The two are never high together.
- R5: A value of zero produces no strobes.
- R6: Within a window, consecutive strobes are at least floor(WINDOW_SLOTS/|value|) slots apart.
- R7: The value is captured only in the load cycle and at the last cycle of each window. A change at any other time has no effect until the next window.
- R8: The prescaler advances by 1 per enabled cycle, by 2 in a `step_up` cycle and by 0 in a `step_down` cycle. A tick appears in the cycle after each wrap. Counting from the load cycle, the ticks seen in cycles 1..N equal floor((N + ups − downs)/PRESC_LEN), where ups and downs are the strobes in cycles 0..N−1. With a value of zero, the first tick is in cycle PRESC_LEN.
- R9: `tick_1hz` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables the prescaler and the correction |
| corr_value | input | 8 | Signed correction, two's complement |
| step_up | output | 1 | Prescaler advanced by two this cycle |
| step_down | output | 1 | Prescaler held this cycle |
| tick_1hz | output | 1 | Corrected tick, one cycle wide |

## Verification
The bench goes after these corner cases:

- **Magnitude -128.** A design that did not clamp it would give 128 steps or take it as zero.
- **Magnitude 127 against a window barely longer.** Here an accumulator that failed to wrap would lose or double steps.
- **Value change in mid-window.** A design capturing continuously would spread the new count over the old window.
- **Zero value.** The tick must still come every PRESC_LEN cycles.
- **Tick count.** The count of ticks over a window is checked against the advance predicted from the strobes. A prescaler that stepped by the wrong amount, or let a step hide a wrap, would be off by several ticks.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    // Control states of the corrector
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } dfc_state_t;

    localparam int CORR_W   = 8;
    localparam int MAG_W    = CORR_W - 1;
    localparam int CORR_MAX = (1 << MAG_W) - 1;
endpackage

// File: rtl/dfc_slot_timer.sv
module dfc_slot_timer #(
    parameter int SLOT_LEN     = 1024,
    parameter int WINDOW_SLOTS = 976
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic slot_last,
    output logic window_last
);
    localparam int SW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam int WW = (WINDOW_SLOTS > 1) ? $clog2(WINDOW_SLOTS) : 1;

    logic [SW-1:0] slot_cnt_q;
    logic [WW-1:0] win_cnt_q;

    assign slot_last   = run && (slot_cnt_q == SW'(SLOT_LEN - 1));
    assign window_last = slot_last && (win_cnt_q == WW'(WINDOW_SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt_q <= '0;
            win_cnt_q  <= '0;
        end else if (clear) begin
            slot_cnt_q <= '0;
            win_cnt_q  <= '0;
        end else if (run) begin
            if (slot_last) begin
                slot_cnt_q <= '0;
                win_cnt_q  <= window_last ? '0 : win_cnt_q + 1'b1;
            end else begin
                slot_cnt_q <= slot_cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfc_spreader.sv
module dfc_spreader
    import dfc_pkg::*;
#(
    parameter int WINDOW_SLOTS = 976
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CORR_W-1:0] value,
    input  logic              slot_end,
    output logic              step_due,
    output logic              step_neg,
    output logic [MAG_W-1:0]  mag_q
);
    localparam int AW = $clog2(WINDOW_SLOTS + CORR_MAX + 1);

    logic [MAG_W-1:0] mag_in;
    logic [AW-1:0]    acc_q;
    logic [AW-1:0]    sum;
    logic             neg_q;

    // Magnitude of the two's complement value; the most negative code saturates
    always_comb begin
        if (!value[CORR_W-1])
            mag_in = value[MAG_W-1:0];
        else if (value[MAG_W-1:0] == '0)
            mag_in = MAG_W'(CORR_MAX);
        else
            mag_in = ~value[MAG_W-1:0] + 1'b1;
    end

    assign sum      = acc_q + AW'(mag_q);
    assign step_due = slot_end && (sum >= AW'(WINDOW_SLOTS));
    assign step_neg = neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
            acc_q <= '0;
        end else if (load) begin
            mag_q <= mag_in;
            neg_q <= value[CORR_W-1];
            acc_q <= '0;
        end else if (slot_end) begin
            acc_q <= step_due ? sum - AW'(WINDOW_SLOTS) : sum;
        end
    end
endmodule

// File: rtl/dfc_prescaler.sv
module dfc_prescaler #(
    parameter int PRESC_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic adv_two,
    input  logic hold,
    output logic tick
);
    localparam int PW  = $clog2(PRESC_LEN);
    localparam int PW1 = PW + 1;

    logic [PW-1:0] cnt_q;
    logic [PW:0]   wide;
    logic [1:0]    inc;

    always_comb begin
        if (hold)
            inc = 2'd0;
        else if (adv_two)
            inc = 2'd2;
        else
            inc = 2'd1;
        wide = {1'b0, cnt_q} + PW1'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (clear) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (run) begin
            cnt_q <= wide[PW-1:0];
            tick  <= wide[PW];
        end else begin
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/dfc_corrector.sv
module dfc_corrector
    import dfc_pkg::*;
#(
    parameter int SLOT_LEN     = 1024,
    parameter int WINDOW_SLOTS = 976,
    parameter int PRESC_LEN    = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [CORR_W-1:0] corr_value,
    output logic                     step_up,
    output logic                     step_down,
    output logic                     tick_1hz
);
    dfc_state_t       state_q, state_d;
    logic             slot_last, window_last;
    logic             step_due, step_neg;
    logic [MAG_W-1:0] spread_mag;
    logic             load_pulse, timer_run, timer_clear;
    logic             presc_run, presc_clear;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = en ? ST_LOAD  : ST_IDLE;   // arm
            ST_LOAD:  state_d = en ? ST_COUNT : ST_IDLE;   // start / disarm
            ST_COUNT: state_d = en ? ST_COUNT : ST_IDLE;   // window wrap / disarm
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs and datapath controls
    always_comb begin
        load_pulse  = 1'b0;
        timer_run   = 1'b0;
        timer_clear = 1'b1;
        presc_run   = 1'b0;
        presc_clear = 1'b1;
        step_up     = 1'b0;
        step_down   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                load_pulse  = 1'b1;
                presc_run   = 1'b1;
                presc_clear = 1'b0;
            end
            ST_COUNT: begin
                timer_run   = 1'b1;
                timer_clear = 1'b0;
                presc_run   = 1'b1;
                presc_clear = 1'b0;
                load_pulse  = window_last;
                step_up     = step_due && !step_neg;
                step_down   = step_due && step_neg;
            end
            default: ;
        endcase
    end

    dfc_slot_timer #(
        .SLOT_LEN     (SLOT_LEN),
        .WINDOW_SLOTS (WINDOW_SLOTS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (timer_clear),
        .run         (timer_run),
        .slot_last   (slot_last),
        .window_last (window_last)
    );

    dfc_spreader #(
        .WINDOW_SLOTS (WINDOW_SLOTS)
    ) u_spread (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_pulse),
        .value    (corr_value),
        .slot_end (slot_last),
        .step_due (step_due),
        .step_neg (step_neg),
        .mag_q    (spread_mag)
    );

    dfc_prescaler #(
        .PRESC_LEN (PRESC_LEN)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (presc_clear),
        .run     (presc_run),
        .adv_two (step_up),
        .hold    (step_down),
        .tick    (tick_1hz)
    );
endmodule

// File: rtl/dfc_corrector_checker.sv
module dfc_corrector_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       step_up,
    input logic       step_down,
    input logic       tick_1hz,
    input logic       slot_last,
    input logic [6:0] mag_q
);
    p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_down));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!step_up && !step_down));

    p_slot_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_down) |-> slot_last);

    p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mag_q == 7'd0) |-> (!step_up && !step_down));

    p_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_down) |=> !(step_up || step_down));

    p_tick_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |=> !tick_1hz);
endmodule

bind dfc_corrector dfc_corrector_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .step_up   (step_up),
    .step_down (step_down),
    .tick_1hz  (tick_1hz),
    .slot_last (slot_last),
    .mag_q     (spread_mag)
);

// File: tb/dfc_corrector_test.sv
module dfc_corrector_test;
    localparam int SLOT = 8;
    localparam int WS   = 130;
    localparam int PL   = 16;
    localparam int WIN  = WS * SLOT;
    localparam int NV   = 8;

    // stimulus value, expected magnitude, expected direction (+1 up, -1 down, 0 none)
    localparam logic [7:0] VEC_VAL [NV] = '{8'd0, 8'd1, 8'd5, 8'hFB, 8'd64, 8'd127, 8'h81, 8'h80};
    localparam int         VEC_MAG [NV] = '{0, 1, 5, 5, 64, 127, 127, 127};
    localparam int         VEC_DIR [NV] = '{0, 1, 1, -1, 1, 1, -1, -1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] corr = 8'd0;
    logic       step_up, step_down, tick_1hz;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dfc_corrector #(
        .SLOT_LEN     (SLOT),
        .WINDOW_SLOTS (WS),
        .PRESC_LEN    (PL)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .corr_value (corr),
        .step_up    (step_up),
        .step_down  (step_down),
        .tick_1hz   (tick_1hz)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_en(input logic v);
        @(posedge clk);
        #1 en = v;
    endtask

    // Drop enable, check quiet outputs, load a value and re-enable
    task automatic restart(input logic [7:0] val);
        drive_en(1'b0);
        repeat (3) @(negedge clk);
        chk(!step_up && !step_down && !tick_1hz, "R1 quiet when disabled",
            int'({step_up, step_down, tick_1hz}), 0);
        @(posedge clk);
        #1 corr = val;
        drive_en(1'b1);
        @(negedge clk);   // still idle
        @(negedge clk);   // load cycle (cycle 0)
    endtask

    task automatic run_vec(input int k);
        int ups = 0, downs = 0, misalign = 0, ticks = 0, first_tick = -1;
        int last = -1, min_gap = 1 << 30, exp_gap, exp_ticks;
        restart(VEC_VAL[k]);
        for (int i = 1; i <= WIN + 1; i++) begin
            @(negedge clk);
            if (tick_1hz) begin
                ticks++;
                if (first_tick < 0) first_tick = i;
            end
            if (step_up || step_down) begin
                if ((i % SLOT) != 0 || i > WIN) misalign++;
                if (i <= WIN) begin
                    if (step_up) ups++;
                    if (step_down) downs++;
                    if (last >= 0 && (i - last) < min_gap) min_gap = i - last;
                    last = i;
                end
            end
        end
        chk(ups == ((VEC_DIR[k] > 0) ? VEC_MAG[k] : 0), "R3 up strobes per window",
            ups, (VEC_DIR[k] > 0) ? VEC_MAG[k] : 0);
        chk(downs == ((VEC_DIR[k] < 0) ? VEC_MAG[k] : 0), "R4 down strobes per window",
            downs, (VEC_DIR[k] < 0) ? VEC_MAG[k] : 0);
        chk(misalign == 0, "R2 strobe slot alignment", misalign, 0);
        exp_ticks = (WIN + 1 + ups - downs) / PL;
        chk(ticks == (WIN + 1 + VEC_DIR[k] * VEC_MAG[k]) / PL && ticks == exp_ticks,
            "R8 corrected tick count", ticks, (WIN + 1 + VEC_DIR[k] * VEC_MAG[k]) / PL);
        if (VEC_MAG[k] >= 2) begin
            exp_gap = (WS / VEC_MAG[k]) * SLOT;
            chk(min_gap >= exp_gap, "R6 even spread gap", min_gap, exp_gap);
        end
        if (VEC_MAG[k] == 0) begin
            chk(ups + downs == 0, "R5 zero value gives no strobes", ups + downs, 0);
            chk(first_tick == PL, "R8 first tick uncorrected", first_tick, PL);
        end
    endtask

    initial begin
        int ups1 = 0, downs1 = 0, ups2 = 0, downs2 = 0;
        repeat (4) @(negedge clk);
        chk(!step_up && !step_down && !tick_1hz, "R1 reset state",
            int'({step_up, step_down, tick_1hz}), 0);
        #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!step_up && !step_down && !tick_1hz, "R1 idle after reset",
            int'({step_up, step_down, tick_1hz}), 0);

        for (int k = 0; k < NV; k++) run_vec(k);

        // R7: value change in mid-window takes effect only at the next window
        restart(8'd10);
        for (int i = 1; i <= 2 * WIN; i++) begin
            @(negedge clk);
            if (i <= WIN) begin
                if (step_up) ups1++;
                if (step_down) downs1++;
            end else begin
                if (step_up) ups2++;
                if (step_down) downs2++;
            end
            if (i == 300) begin
                @(posedge clk);
                #1 corr = 8'hD8;   // -40
            end
        end
        chk(ups1 == 10 && downs1 == 0, "R7 old value kept in window", ups1 * 1000 + downs1, 10000);
        chk(ups2 == 0 && downs2 == 40, "R7 new value next window", ups2 * 1000 + downs2, 40);

        drive_en(1'b0);
        repeat (3) @(negedge clk);
        chk(!step_up && !step_down && !tick_1hz, "R1 quiet after disable",
            int'({step_up, step_down, tick_1hz}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule